// File: doc/BRIEF.md
# Secure Scan Chain Controller

This block wraps the state registers of a small cipher datapath, a key register and a round-state register, in one serial scan chain whose test access cannot be used to read out key material. A registered copy of the test-mode select is compared with its live value. Any difference, in either direction, raises a one-cycle clear that acts like a reset on every cell of the chain, so data cannot be carried across a mode boundary in either direction.

In test mode the chain shifts when scan enable is high and captures functional data when it is low. A key-load strobe in test mode writes zeros, so the secret never reaches a scan-visible register. In functional mode scan enable is ignored. The state register takes the functional data on every clock and the key register loads the key input on its strobe. The chain length is set by two width parameters.

Top module: `secure_scan_ctrl`

## Requirements
- R1: While `rst_n` is low, `key_out`, `state_out` and `scan_out` are all zero.
- R2: A change of `test_mode` in either direction between two clock edges clears both registers at the first edge that sees the new value. Operation in the new mode begins at the following edge.
- R3: During the cycle in which a mode change is pending, `scan_out` reads 0 and the clear overrides shift, capture and key load.
- R4: In test mode with `scan_en` low, a `key_load` strobe writes all zeros into the key register and `key_in` is discarded.
- R5: In functional mode, `key_load` high stores `key_in` into the key register. With `key_load` low the key register holds its value.
- R6: In functional mode `scan_en` has no effect: the state register loads `func_data` on every clock and the chain does not shift.
- R7: In test mode with `scan_en` high, the chain shifts one bit per clock. `scan_in` enters state bit 0, state bit MSB feeds key bit 0, and `scan_out` shows key bit MSB. The chain is therefore read out MSB first, key first and then state, and a `key_load` strobe is ignored while shifting.
- R8: In test mode with `scan_en` low, the state register captures `func_data` and the key register holds its value unless R4 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | 1 = test mode, 0 = functional mode |
| scan_en | input | 1 | Shift request, honoured only in test mode |
| scan_in | input | 1 | Serial data into the chain |
| key_in | input | KEY_W | Parallel secret key |
| key_load | input | 1 | Key load strobe |
| func_data | input | STATE_W | Parallel functional data for the state register |
| scan_out | output | 1 | Serial chain output |
| key_out | output | KEY_W | Key register contents |
| state_out | output | STATE_W | State register contents |

## Verification
The bench switches mode while the key register holds a value with its top bit set. A design without the clear would show that bit on `scan_out` or keep the key after entering test mode. It strobes `key_load` with an all-ones key in test mode, both while capturing and while shifting, which catches a design that lets the secret or a load into the chain. It raises `scan_en` in functional mode, where a leaky design would shift state. It also clocks a full-length pattern through the chain, which exposes a wrong bit order or a wrong join between the key and state segments.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
   typedef enum logic [1:0] {
      SEG_HOLD  = 2'd0,
      SEG_CLEAR = 2'd1,
      SEG_SHIFT = 2'd2,
      SEG_LOAD  = 2'd3
   } seg_op_e;
endpackage

// File: rtl/ssc_mode_watch.sv
module ssc_mode_watch (
   input  logic clk,
   input  logic rst_n,
   input  logic test_mode,
   output logic clr_o
);
   logic mode_q;
   logic seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         seen_q <= 1'b0;
      end else begin
         mode_q <= test_mode;
         seen_q <= 1'b1;
      end
   end

   assign clr_o = test_mode ^ mode_q;

   AST_SWITCH_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && (test_mode != $past(test_mode))) |-> clr_o); // R2
endmodule

// File: rtl/ssc_seg.sv
module ssc_seg
   import ssc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  seg_op_e      op,
   input  logic [W-1:0] load_val,
   input  logic         ser_in,
   output logic [W-1:0] q,
   output logic         ser_out
);
   logic [W-1:0] shifted;

   generate
      if (W < 1) begin : g_bad_w
         $error("ssc_seg: W must be at least 1");
      end
      if (W == 1) begin : g_one
         assign shifted = ser_in;
      end else begin : g_many
         assign shifted = {q[W-2:0], ser_in};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         case (op)
            SEG_CLEAR: q <= '0;
            SEG_SHIFT: q <= shifted;
            SEG_LOAD:  q <= load_val;
            default:   q <= q;
         endcase
      end
   end

   assign ser_out = q[W-1];
endmodule

// File: rtl/secure_scan_ctrl.sv
module secure_scan_ctrl
   import ssc_pkg::*;
#(
   parameter int KEY_W   = 32,
   parameter int STATE_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               test_mode,
   input  logic               scan_en,
   input  logic               scan_in,
   input  logic [KEY_W-1:0]   key_in,
   input  logic               key_load,
   input  logic [STATE_W-1:0] func_data,
   output logic               scan_out,
   output logic [KEY_W-1:0]   key_out,
   output logic [STATE_W-1:0] state_out
);
   localparam int CHAIN_W = KEY_W + STATE_W;

   generate
      if (KEY_W < 1 || STATE_W < 1) begin : g_bad_w
         $error("secure_scan_ctrl: segment widths must be positive");
      end
      if (CHAIN_W < 2) begin : g_bad_chain
         $error("secure_scan_ctrl: chain too short");
      end
   endgenerate

   logic         clr;
   logic         shift_req;
   seg_op_e      key_op;
   seg_op_e      state_op;
   logic [KEY_W-1:0] key_val;
   logic         state_msb;
   logic         key_msb;

   ssc_mode_watch u_watch (
      .clk       (clk),
      .rst_n     (rst_n),
      .test_mode (test_mode),
      .clr_o     (clr)
   );

   assign shift_req = test_mode & scan_en;
   assign key_val   = test_mode ? '0 : key_in;

   always_comb begin
      if (clr)            key_op = SEG_CLEAR;
      else if (shift_req) key_op = SEG_SHIFT;
      else if (key_load)  key_op = SEG_LOAD;
      else                key_op = SEG_HOLD;
   end

   always_comb begin
      if (clr)            state_op = SEG_CLEAR;
      else if (shift_req) state_op = SEG_SHIFT;
      else                state_op = SEG_LOAD;
   end

   ssc_seg #(.W(STATE_W)) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (state_op),
      .load_val (func_data),
      .ser_in   (scan_in),
      .q        (state_out),
      .ser_out  (state_msb)
   );

   ssc_seg #(.W(KEY_W)) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (key_op),
      .load_val (key_val),
      .ser_in   (state_msb),
      .q        (key_out),
      .ser_out  (key_msb)
   );

   assign scan_out = clr ? 1'b0 : key_msb;

   AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (key_out == '0 && state_out == '0)); // R2
   AST_SO_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      clr |-> !scan_out); // R3
   AST_NO_KEY_IN_TEST: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && !scan_en && key_load && !clr) |=> key_out == '0); // R4
   AST_FUNC_KEY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode && key_load && !clr) |=> key_out == $past(key_in)); // R5
   AST_FUNC_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode && !clr) |=> state_out == $past(func_data)); // R6
   AST_FUNC_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode && !clr && !key_load) |=> $stable(key_out)); // R5
   AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && scan_en && !clr) |=> state_out[0] == $past(scan_in)); // R7
   AST_SHIFT_JOIN: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && scan_en && !clr) |=> key_out[0] == $past(state_out[STATE_W-1])); // R7
endmodule

// File: tb/sim_secure_scan_ctrl.sv
module sim_secure_scan_ctrl;
   localparam int KW = 32;
   localparam int SW = 32;
   localparam int NV = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          test_mode = 1'b0;
   logic          scan_en = 1'b0;
   logic          scan_in = 1'b0;
   logic [KW-1:0] key_in = '0;
   logic          key_load = 1'b0;
   logic [SW-1:0] func_data = '0;
   logic          scan_out;
   logic [KW-1:0] key_out;
   logic [SW-1:0] state_out;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   secure_scan_ctrl #(.KEY_W(KW), .STATE_W(SW)) u0 (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .scan_en(scan_en),
      .scan_in(scan_in), .key_in(key_in), .key_load(key_load),
      .func_data(func_data), .scan_out(scan_out), .key_out(key_out),
      .state_out(state_out)
   );

   // {tm, se, si, kl, key_in, func_data, exp_key, exp_state, exp_so}
   localparam logic [132:0] VEC [0:NV-1] = '{
      {4'b0001, 32'hA5A5_0001, 32'h1234_5678, 32'hA5A5_0001, 32'h1234_5678, 1'b1}, // R5
      {4'b0100, 32'h0,         32'h0000_00FF, 32'hA5A5_0001, 32'h0000_00FF, 1'b1}, // R6
      {4'b1000, 32'h0,         32'h0000_DEAD, 32'h0,         32'h0,         1'b0}, // R2
      {4'b1001, 32'hFFFF_FFFF, 32'h8000_0001, 32'h0,         32'h8000_0001, 1'b0}, // R4
      {4'b1110, 32'h0,         32'h0,         32'h0000_0001, 32'h0000_0003, 1'b0}, // R7
      {4'b1101, 32'hFFFF_FFFF, 32'h0,         32'h0000_0002, 32'h0000_0006, 1'b0}, // R7
      {4'b1000, 32'h0,         32'h0000_0042, 32'h0000_0002, 32'h0000_0042, 1'b0}, // R8
      {4'b0001, 32'h1111_1111, 32'h0000_0007, 32'h0,         32'h0,         1'b0}, // R2 R3
      {4'b0001, 32'h8000_0000, 32'h0000_0009, 32'h8000_0000, 32'h0000_0009, 1'b1}, // R5
      {4'b0000, 32'h0,         32'h0000_0005, 32'h8000_0000, 32'h0000_0005, 1'b1}  // R5 R6
   };

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [63:0] got;
      logic [63:0] pat;
      // R1: reset state
      repeat (3) step();
      chk(key_out == '0 && state_out == '0 && scan_out == 1'b0, "R1",
          {key_out, state_out}, 64'h0);
      rst_n = 1'b1;
      step();

      for (int i = 0; i < NV; i++) begin
         {test_mode, scan_en, scan_in, key_load} = VEC[i][132:129];
         key_in    = VEC[i][128:97];
         func_data = VEC[i][96:65];
         step();
         chk(key_out == VEC[i][64:33], $sformatf("R2-8 vec%0d key", i),
             64'(key_out), 64'(VEC[i][64:33]));
         chk(state_out == VEC[i][32:1], $sformatf("R2-8 vec%0d state", i),
             64'(state_out), 64'(VEC[i][32:1]));
         chk(scan_out == VEC[i][0], $sformatf("R7 vec%0d scan_out", i),
             64'(scan_out), 64'(VEC[i][0]));
      end

      // R3: key MSB is 1, switch to test mode; scan_out dark during the clear cycle
      test_mode = 1'b1; key_load = 1'b1; key_in = 32'hFFFF_FFFF; scan_en = 1'b0;
      #1;
      chk(scan_out == 1'b0, "R3 scan_out during clear", 64'(scan_out), 64'h0);
      step();
      chk(key_out == '0 && state_out == '0, "R3 clear beats load",
          {key_out, state_out}, 64'h0);

      // R7: capture, then read the whole chain out MSB first
      key_load = 1'b0; func_data = 32'hC000_0001;
      step();
      pat = 64'hF0E1_D2C3_B4A5_9687;
      scan_en = 1'b1;
      for (int i = 0; i < KW + SW; i++) begin
         scan_in = pat[63 - i];
         #1;
         got[63 - i] = scan_out;
         step();
      end
      chk(got == 64'h0000_0000_C000_0001, "R7 serial readout order", got,
          64'h0000_0000_C000_0001);
      chk({key_out, state_out} == pat, "R7 shifted-in pattern",
          {key_out, state_out}, pat);

      // R4: a key strobe while shifting is ignored; bits keep flowing
      key_load = 1'b1; key_in = 32'hFFFF_FFFF; scan_in = 1'b0;
      step();
      chk({key_out, state_out} == {pat[62:0], 1'b0}, "R4 R7 key strobe while shifting",
          {key_out, state_out}, {pat[62:0], 1'b0});

      // R2: back to functional mode with scan_en still high, clear then R6
      key_load = 1'b0; test_mode = 1'b0; func_data = 32'h0000_0ABC;
      step();
      chk({key_out, state_out} == 64'h0, "R2 test->func clear",
          {key_out, state_out}, 64'h0);
      step();
      chk(state_out == 32'h0000_0ABC && key_out == '0, "R6 scan_en ignored",
          {key_out, state_out}, {32'h0, 32'h0000_0ABC});

      // R1: reset mid-run
      key_load = 1'b1; key_in = 32'h1357_9BDF;
      step();
      rst_n = 1'b0;
      #1;
      chk(key_out == '0 && state_out == '0 && scan_out == 1'b0, "R1 async reset",
          {key_out, state_out}, 64'h0);
      summary();
   end
endmodule